// File: doc/BRIEF.md
# Continuous Frame CRC Scrubber

This block patrols a configuration memory for soft errors in the background. The memory is organised as rows called frames. Each row holds a data field and, in its 32 least significant bits, a check word computed when the row was written. The scrubber fetches one row at a time through a synchronous read port and folds the whole row, data and check word together, through a CRC-32C shift register that starts at zero. A row whose residue is zero is clean, and the scan moves on to the next row. When the scan passes the last row it returns to row 0, and it keeps looping until reset.

A non-zero residue sets a sticky error flag and starts a search. The search walks the row's bit positions from 0 upward. At each position it compares the residue with the residue that a flip of that single bit would leave, and then with the residue a flip of that bit and the bit above it would leave. The first match is reported together with the row index and a type code. If the walk reaches the top bit with no match, the row is reported as unlocatable. Scanning then continues with the following row. The block never repairs the memory.

The state machine has four states. In IDLE it waits for `scan_en`. FETCH issues the read. CHECK takes the returned row and registers its residue. LOCATE performs the search, one bit position per cycle. Transitions:
- IDLE→FETCH when enabled.
- FETCH→CHECK always.
- CHECK→FETCH on a clean row when enabled, or CHECK→IDLE on a clean row when disabled.
- CHECK→LOCATE on a non-zero residue.
- LOCATE→LOCATE while no candidate has matched and the top bit has not been reached.
- LOCATE→FETCH or LOCATE→IDLE when the search ends, depending on `scan_en`.

Top module: `frame_crc_scrubber`

## Requirements
- R1: After reset `mem_rd`, `fault_seen`, `rpt_valid`, `rpt_frame`, `rpt_bit` and `rpt_kind` are all zero.
- R2: A row is `{data, check}` with the check word in bits 31:0, where check = data(x)·x^32 mod G and G is CRC-32C (0x1EDC6F41). Rows built this way never raise `fault_seen` and never produce a report.
- R3: While enabled, reads visit rows 0,1,…,FRAMES-1 in order and then wrap to 0. `mem_rd` is never high on two consecutive cycles, and the row is taken on the cycle after the read.
- R4: With `scan_en` low, the block finishes its current row and issues no further read.
- R5: A row with a non-zero residue sets `fault_seen`, which stays high until reset even after the memory is clean again.
- R6: A single flipped bit at row position p (0 = LSB of the check word, FRAME_W-1 = MSB of the data) is reported with `rpt_kind` = 01 and `rpt_bit` = p.
- R7: Two flipped neighbouring bits p and p+1 are reported with `rpt_kind` = 10 and `rpt_bit` = p.
- R8: Any other pattern of 3, 4 or 5 flipped bits in one row is still reported, with `rpt_kind` = 11 and `rpt_bit` = 0.
- R9: `rpt_valid` is high for exactly one cycle per faulty row. `rpt_frame` carries that row's index, `rpt_kind` is never 00 during a report, and all report fields hold their values until the next report.
- R10: In the cycle that `rpt_valid` is high, the scanner is already reading the next row, (index+1) mod FRAMES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | Allows scanning; sampled at row boundaries |
| mem_rd | output | 1 | Read request for one row |
| mem_row | output | $clog2(FRAMES) | Row index being read |
| mem_q | input | DATA_W+32 | Row contents, valid the cycle after `mem_rd` |
| fault_seen | output | 1 | Sticky flag: some row had a non-zero residue |
| rpt_valid | output | 1 | One-cycle report strobe |
| rpt_frame | output | $clog2(FRAMES) | Row index of the report |
| rpt_bit | output | $clog2(DATA_W+32) | Lowest flipped bit position, or 0 |
| rpt_kind | output | 2 | 00 none, 01 single, 10 adjacent pair, 11 unlocatable |

## Verification
The bound checker verifies the following on every cycle:
- the strobe lasts one cycle and always carries a non-zero type;
- `fault_seen` never falls, and every report happens under it;
- reads never come back to back, addresses stay in range, and no read follows a low `scan_en`;
- the reported offset lies inside the row.

Whether the offset and type are actually correct can only be shown by the bench's scenarios. The bench sweeps every single-bit flip in every row and every adjacent pair in one row, uses chosen 3-, 4- and 5-bit patterns, and checks the read order, the stop on disable and the persistence of the flag.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int          SIG_W    = 32;
    localparam logic [31:0] SIG_POLY = 32'h1EDC_6F41;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_SINGLE = 2'b01,
        KIND_PAIR   = 2'b10,
        KIND_UNLOC  = 2'b11
    } fault_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_LOCATE
    } scan_state_e;

    // multiply a residue by x modulo the generator
    function automatic logic [SIG_W-1:0] mul_x(input logic [SIG_W-1:0] v);
        return {v[SIG_W-2:0], 1'b0} ^ (v[SIG_W-1] ? SIG_POLY : '0);
    endfunction

endpackage

// File: rtl/fcs_residue.sv
module fcs_residue
    import fcs_pkg::*;
#(
    parameter int ROW_W = 96
) (
    input  logic [ROW_W-1:0] row,
    output logic [SIG_W-1:0] residue
);

    // serial shift register, most significant row bit first, zero start
    function automatic logic [SIG_W-1:0] fold(input logic [ROW_W-1:0] r);
        logic [SIG_W-1:0] acc;
        logic             fb;
        acc = '0;
        for (int i = ROW_W - 1; i >= 0; i--) begin
            fb  = acc[SIG_W-1] ^ r[i];
            acc = {acc[SIG_W-2:0], 1'b0} ^ ({SIG_W{fb}} & SIG_POLY);
        end
        return acc;
    endfunction

    always_comb residue = fold(row);

endmodule

// File: rtl/fcs_walker.sv
module fcs_walker
    import fcs_pkg::*;
#(
    parameter int ROW_W = 96,
    localparam int POS_W = $clog2(ROW_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [POS_W-1:0] pos,
    output logic [SIG_W-1:0] syn_here,
    output logic [SIG_W-1:0] syn_above,
    output logic             at_top
);

    // syn_here = x^(pos+32) mod G: residue left by flipping bit pos
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos      <= '0;
            syn_here <= '0;
        end else if (load) begin
            pos      <= '0;
            syn_here <= SIG_POLY;
        end else if (step) begin
            pos      <= pos + 1'b1;
            syn_here <= mul_x(syn_here);
        end
    end

    always_comb begin
        syn_above = mul_x(syn_here);
        at_top    = (pos == POS_W'(ROW_W - 1));
    end

endmodule

// File: rtl/fcs_frame_ptr.sv
module fcs_frame_ptr #(
    parameter int FRAMES = 16,
    localparam int ADDR_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [ADDR_W-1:0] idx
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (advance)
            idx <= (idx == ADDR_W'(FRAMES - 1)) ? '0 : idx + 1'b1;
    end

endmodule

// File: rtl/frame_crc_scrubber.sv
module frame_crc_scrubber
    import fcs_pkg::*;
#(
    parameter int FRAMES = 16,
    parameter int DATA_W = 64,
    localparam int ROW_W  = DATA_W + SIG_W,
    localparam int ADDR_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    localparam int POS_W  = $clog2(ROW_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_row,
    input  logic [ROW_W-1:0]  mem_q,
    output logic              fault_seen,
    output logic              rpt_valid,
    output logic [ADDR_W-1:0] rpt_frame,
    output logic [POS_W-1:0]  rpt_bit,
    output logic [1:0]        rpt_kind
);

    scan_state_e      state, state_nx;
    logic [SIG_W-1:0] residue, syn_q;
    logic [SIG_W-1:0] syn_here, syn_above;
    logic [POS_W-1:0] pos;
    logic             at_top, hit_one, hit_two, search_done;
    logic             row_bad, ptr_adv;
    logic [ADDR_W-1:0] cur_row;

    fcs_residue #(.ROW_W(ROW_W)) u_residue (
        .row     (mem_q),
        .residue (residue)
    );

    fcs_walker #(.ROW_W(ROW_W)) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state == ST_CHECK),
        .step      (state == ST_LOCATE && !search_done),
        .pos       (pos),
        .syn_here  (syn_here),
        .syn_above (syn_above),
        .at_top    (at_top)
    );

    fcs_frame_ptr #(.FRAMES(FRAMES)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (ptr_adv),
        .idx     (cur_row)
    );

    // candidate comparison for the current bit position
    always_comb begin
        row_bad     = (residue != '0);
        hit_one     = (syn_q == syn_here);
        hit_two     = !at_top && (syn_q == (syn_here ^ syn_above));
        search_done = hit_one || hit_two || at_top;
        ptr_adv     = (state == ST_CHECK && !row_bad) ||
                      (state == ST_LOCATE && search_done);
        mem_rd      = (state == ST_FETCH);
        mem_row     = cur_row;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = scan_en ? ST_FETCH : ST_IDLE;
            ST_FETCH:  state_nx = ST_CHECK;
            ST_CHECK:  state_nx = row_bad ? ST_LOCATE
                                          : (scan_en ? ST_FETCH : ST_IDLE);
            ST_LOCATE: state_nx = !search_done ? ST_LOCATE
                                               : (scan_en ? ST_FETCH : ST_IDLE);
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register and residue capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            syn_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_CHECK)
                syn_q <= residue;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_seen <= 1'b0;
            rpt_valid  <= 1'b0;
            rpt_frame  <= '0;
            rpt_bit    <= '0;
            rpt_kind   <= KIND_NONE;
        end else begin
            if (state == ST_CHECK && row_bad)
                fault_seen <= 1'b1;
            rpt_valid <= (state == ST_LOCATE) && search_done;
            if (state == ST_LOCATE && search_done) begin
                rpt_frame <= cur_row;
                if (hit_one) begin
                    rpt_bit  <= pos;
                    rpt_kind <= KIND_SINGLE;
                end else if (hit_two) begin
                    rpt_bit  <= pos;
                    rpt_kind <= KIND_PAIR;
                end else begin
                    rpt_bit  <= '0;
                    rpt_kind <= KIND_UNLOC;
                end
            end
        end
    end

endmodule

// File: rtl/frame_crc_scrubber_checker.sv
module frame_crc_scrubber_checker #(
    parameter int FRAMES = 16,
    parameter int ROW_W  = 96,
    localparam int ADDR_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    localparam int POS_W  = $clog2(ROW_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_en,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_row,
    input logic              fault_seen,
    input logic              rpt_valid,
    input logic [POS_W-1:0]  rpt_bit,
    input logic [1:0]        rpt_kind
);

    assert_kind_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> rpt_kind != 2'b00);

    assert_strobe_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |=> !rpt_valid);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_seen |=> fault_seen);

    assert_report_under_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> fault_seen);

    assert_row_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (32'(mem_row) < 32'(FRAMES)));

    assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    assert_halt_on_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> !mem_rd);

    assert_offset_in_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> (32'(rpt_bit) < 32'(ROW_W)));

endmodule

bind frame_crc_scrubber frame_crc_scrubber_checker #(
    .FRAMES (FRAMES),
    .ROW_W  (ROW_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en    (scan_en),
    .mem_rd     (mem_rd),
    .mem_row    (mem_row),
    .fault_seen (fault_seen),
    .rpt_valid  (rpt_valid),
    .rpt_bit    (rpt_bit),
    .rpt_kind   (rpt_kind)
);

// File: tb/frame_crc_scrubber_test.sv
module frame_crc_scrubber_test;

    localparam int FR = 4;
    localparam int DW = 32;
    localparam int RW = DW + 32;
    localparam logic [31:0] GEN = 32'h1EDC_6F41;
    localparam int WAIT_LIM = FR * 4 + RW + 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_en = 1'b0;
    logic          mem_rd;
    logic [1:0]    mem_row;
    logic [RW-1:0] mem_q;
    logic          fault_seen, rpt_valid;
    logic [1:0]    rpt_frame;
    logic [5:0]    rpt_bit;
    logic [1:0]    rpt_kind;

    logic [RW-1:0] mem  [FR];
    logic [RW-1:0] good [FR];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    frame_crc_scrubber #(.FRAMES(FR), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
        .mem_rd(mem_rd), .mem_row(mem_row), .mem_q(mem_q),
        .fault_seen(fault_seen), .rpt_valid(rpt_valid),
        .rpt_frame(rpt_frame), .rpt_bit(rpt_bit), .rpt_kind(rpt_kind)
    );

    // storage model: one-cycle read latency
    always_ff @(posedge clk) if (mem_rd) mem_q <= mem[mem_row];

    // check word by polynomial long division of data*x^32
    function automatic logic [31:0] check_word(input logic [DW-1:0] d);
        logic [RW-1:0] t;
        t = {d, 32'b0};
        for (int i = RW - 1; i >= 32; i--)
            if (t[i]) t[i -: 33] = t[i -: 33] ^ {1'b1, GEN};
        return t[31:0];
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    // inject mask into row f, run until one report, verify it
    task automatic run_case(input int f, input logic [RW-1:0] mask,
                            input int kind, input int off, input string req);
        bit got;
        int rf, rb, rk, nxt_ok, nxt_addr;
        scan_en = 1'b0;
        repeat (RW + 10) @(negedge clk);
        mem[f] = good[f] ^ mask;
        scan_en = 1'b1;
        got = 0;
        for (int c = 0; c < WAIT_LIM && !got; c++) begin
            @(negedge clk);
            if (rpt_valid) begin
                got = 1;
                rf = rpt_frame; rb = rpt_bit; rk = rpt_kind;
                nxt_ok = mem_rd; nxt_addr = mem_row;
                scan_en = 1'b0;
            end
        end
        check(got, {req, " report seen"}, got, 1);
        if (got) begin
            check(rk == kind, {req, " kind"}, rk, kind);
            check(rb == off, {req, " offset"}, rb, off);
            check(rf == f, "R9 frame index", rf, f);
            check(nxt_ok == 1 && nxt_addr == (f + 1) % FR, "R10 next row read",
                  nxt_addr, (f + 1) % FR);
            @(negedge clk);
            check(!rpt_valid && rpt_bit == off, "R9 strobe one cycle, fields held",
                  rpt_valid, 0);
        end
        repeat (RW + 10) @(negedge clk);
        mem[f] = good[f];
    endtask

    initial begin
        int addr_bad, reads, saw_rpt;
        logic [RW-1:0] m;
        for (int f = 0; f < FR; f++) begin
            logic [DW-1:0] d;
            d = DW'(32'h9E37_79B9 * (f + 3)) ^ DW'(32'h5A5A_0F0F);
            good[f] = {d, check_word(d)};
            mem[f]  = good[f];
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!mem_rd && !fault_seen && !rpt_valid && rpt_kind == 0 &&
              rpt_bit == 0 && rpt_frame == 0, "R1 reset outputs", rpt_kind, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 read order and wrap; R2 clean rows raise nothing
        scan_en = 1'b1;
        addr_bad = 0; reads = 0; saw_rpt = 0;
        for (int c = 0; c < 6 * FR; c++) begin
            @(negedge clk);
            if (rpt_valid) saw_rpt++;
            if (mem_rd) begin
                if (mem_row != reads % FR) addr_bad++;
                reads++;
            end
        end
        check(reads == 3 * FR, "R3 one read per two cycles", reads, 3 * FR);
        check(addr_bad == 0, "R3 row order with wrap", addr_bad, 0);
        check(!fault_seen && saw_rpt == 0, "R2 clean rows silent", saw_rpt, 0);

        // R4 disable stops reads
        scan_en = 1'b0;
        repeat (4) @(negedge clk);
        reads = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (mem_rd) reads++;
        end
        check(reads == 0, "R4 no reads while disabled", reads, 0);

        // R6 every single-bit flip in every row
        for (int f = 0; f < FR; f++)
            for (int p = 0; p < RW; p++) begin
                m = '0; m[p] = 1'b1;
                run_case(f, m, 1, p, "R6 single");
            end

        // R5 flag survives repaired memory
        check(fault_seen, "R5 flag after fault", fault_seen, 1);

        // R7 every adjacent pair in row 2
        for (int p = 0; p < RW - 1; p++) begin
            m = '0; m[p] = 1'b1; m[p + 1] = 1'b1;
            run_case(2, m, 2, p, "R7 pair");
        end

        // R8 wider patterns
        m = '0; m[0] = 1; m[2] = 1; m[4] = 1;
        run_case(1, m, 3, 0, "R8 three bits");
        m = '0; m[1] = 1; m[5] = 1; m[9] = 1; m[20] = 1;
        run_case(3, m, 3, 0, "R8 four bits");
        m = '0; m[3] = 1; m[10] = 1; m[17] = 1; m[30] = 1; m[50] = 1;
        run_case(0, m, 3, 0, "R8 five bits");
        m = '0; m[40] = 1; m[41] = 1; m[42] = 1;
        run_case(2, m, 3, 0, "R8 three in a run");

        // R5 sticky through a clean sweep, cleared by reset
        scan_en = 1'b1;
        saw_rpt = 0;
        for (int c = 0; c < 4 * FR; c++) begin
            @(negedge clk);
            if (rpt_valid) saw_rpt++;
        end
        check(fault_seen && saw_rpt == 0, "R5 flag held on clean memory", fault_seen, 1);
        scan_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(!fault_seen && rpt_kind == 0, "R1 reset clears flag", fault_seen, 0);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end

endmodule